// File: doc/BRIEF.md
# Prescaled Decrementing Timer with Capture

This block is a periodic interval timer. Ticks come either from a divide-by-16 strobe of the system clock or from rising edges on an asynchronous event pin. A small prescaler divides those ticks. Each prescaler underflow decrements an 8-bit counter. When the counter underflows, it reloads and emits a one-cycle interrupt request. The firmware-visible side is a byte bus with two addresses: a data address and a control address. The control byte holds the run flag, the source select and the prescale reload.

A separate asynchronous capture strobe snapshots the live counter into a capture latch. A read of the control address returns that latch and not the control byte. Software can therefore timestamp an external event against the running count.

Top module: `prescaled_capture_timer`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the data-address read and the control-address read both return 0, and tick_irq is low.
- R2: A write to the data address (bus_addr = 0) loads both the reload value and the live counter. A read of the data address returns the live counter.
- R3: Control bits 4:0 hold the prescale value p. Each decrement of the counter takes p+1 selected ticks, and the prescaler reloads from p on underflow.
- R4: After the counter has been decremented at 0, it reloads from the reload value r, so it decrements r+1 times per period. At that reload, tick_irq is high for exactly one clock cycle.
- R5: With control bit 6 = 0 and bit 7 = 1, the interval between two consecutive tick_irq pulses is 16·(p+1)·(r+1) clock cycles.
- R6: With control bit 6 = 1, each rising edge of event_in is one tick and the system-clock strobe has no effect.
- R7: With control bit 7 = 0 the timer is stopped: event edges and the clock strobe leave the counter unchanged.
- R8: The prescaler reloads from the written bits 4:0 only when a control write (bus_addr = 1) takes bit 7 from 0 to 1. A control write while the timer is already running leaves the prescaler's count as it was.
- R9: A rising edge of capture_in copies the live counter into the capture latch. A read of the control address returns the latch, and the latch holds until the next capture edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 1 | 0 = data/counter, 1 = control (write) / capture latch (read) |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| event_in | input | 1 | Asynchronous external event input |
| capture_in | input | 1 | Asynchronous capture strobe |
| tick_irq | output | 1 | One-cycle interrupt request on counter reload |

## Verification
The hardest conditions to reach are the exact prescaler phase at the moment of a control rewrite and the counter value at the moment of a capture. With the free-running clock divider, neither can be placed precisely from the ports. The stimulus therefore runs these cases in event mode. There every tick is a deliberate event_in pulse, so the bench knows the prescaler and counter positions exactly. The bench sweeps every prescale and reload pair from 0 to 3 and predicts the counter value and pulse count arithmetically. The divider-driven mode is then checked only by measuring the spacing between interrupts.

// File: rtl/tmr_pkg.sv
// Package: shared address codes and control-field positions for the timer.
// Assumes the bus width equals the counter width and the control byte
// carries run in its top bit and source select just below it.
package tmr_pkg;
    typedef enum logic {
        ADDR_COUNT = 1'b0,
        ADDR_CTRL  = 1'b1
    } tmr_addr_e;

    // Offsets of control flags counted down from the top bit
    localparam int RUN_FROM_TOP = 1;
    localparam int SRC_FROM_TOP = 2;
endpackage

// File: rtl/tmr_edge_sync.sv
// Module: synchronizes an asynchronous input through STAGES flops and
// flags its rising edge for one clock. Assumes STAGES >= 2.
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] shift_q;

    // Shift the input through the synchronizer plus one history stage
    always_ff @(posedge clk) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= {shift_q[STAGES-1:0], async_in};
    end

    assign rise = shift_q[STAGES-1] & ~shift_q[STAGES];

    // R6 / R9: a detected edge never lasts two cycles
    assert_rise_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/tmr_tick_src.sv
// Module: produces the timer tick. A free-running DIV_W-bit counter gives
// one strobe per 2**DIV_W clocks; a synchronized event edge is the
// alternative source. The tick is gated by the run flag. Assumes DIV_W >= 2.
module tmr_tick_src #(
    parameter int DIV_W  = 4,
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic use_event,
    input  logic event_in,
    output logic tick
);
    logic [DIV_W-1:0] div_q;
    logic             sys_tick;
    logic             evt_rise;

    // Free-running clock divider
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    assign sys_tick = &div_q;

    tmr_edge_sync #(.STAGES(STAGES)) u_evt_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (event_in),
        .rise     (evt_rise)
    );

    assign tick = run & (use_event ? evt_rise : sys_tick);

    // R5: the divider strobe is isolated
    assert_sys_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sys_tick |=> !sys_tick);
endmodule

// File: rtl/tmr_count_core.sv
// Module: holds the control byte and the reload value, and runs the
// prescaler and counter that step on each tick. A bus write takes priority
// over a tick in the same cycle. Assumes PRE_W <= CNT_W - 2.
module tmr_count_core
    import tmr_pkg::*;
#(
    parameter int PRE_W = 5,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_count,
    input  logic             wr_ctrl,
    input  logic [CNT_W-1:0] wdata,
    output logic             run,
    output logic             use_event,
    output logic [CNT_W-1:0] count,
    output logic             irq
);
    localparam int RUN_BIT = CNT_W - RUN_FROM_TOP;
    localparam int SRC_BIT = CNT_W - SRC_FROM_TOP;

    logic [CNT_W-1:0] ctrl_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PRE_W-1:0] pre_q;
    logic             irq_q;

    assign run       = ctrl_q[RUN_BIT];
    assign use_event = ctrl_q[SRC_BIT];
    assign count     = cnt_q;
    assign irq       = irq_q;

    // Prescaler/counter stepping, then bus writes override
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            reload_q <= '0;
            cnt_q    <= '0;
            pre_q    <= '0;
            irq_q    <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (tick) begin
                if (pre_q == '0) begin
                    pre_q <= ctrl_q[PRE_W-1:0];
                    if (cnt_q == '0) begin
                        cnt_q <= reload_q;
                        irq_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end else begin
                    pre_q <= pre_q - 1'b1;
                end
            end
            if (wr_count) begin
                reload_q <= wdata;
                cnt_q    <= wdata;
            end
            if (wr_ctrl) begin
                ctrl_q <= wdata;
                if (!ctrl_q[RUN_BIT] && wdata[RUN_BIT])
                    pre_q <= wdata[PRE_W-1:0];
            end
        end
    end

    // R4: the request is a single-cycle pulse
    assert_irq_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);
    // R4: while the request is high the counter sits at its reload value
    assert_irq_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (cnt_q == reload_q));
    // R7: a stopped timer holds its count unless the data address is written
    assert_stopped_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_count) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_capture.sv
// Module: copies the live count into a latch on a synchronized rising
// edge of the capture strobe.
module tmr_capture #(
    parameter int CNT_W  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture_in,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] latched
);
    logic cap_rise;
    logic [CNT_W-1:0] latch_q;

    tmr_edge_sync #(.STAGES(STAGES)) u_cap_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (capture_in),
        .rise     (cap_rise)
    );

    // Snapshot the count on a capture edge
    always_ff @(posedge clk) begin
        if (!rst_n)        latch_q <= '0;
        else if (cap_rise) latch_q <= count;
    end

    assign latched = latch_q;

    // R9: without an edge the latch holds
    assert_latch_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_rise |=> $stable(latch_q));
endmodule

// File: rtl/prescaled_capture_timer.sv
// Module: top of the prescaled decrementing timer. Decodes the two-address
// byte bus, selects the tick source, runs the counter and exposes the
// capture latch on control-address reads. Read data is combinational.
module prescaled_capture_timer
    import tmr_pkg::*;
#(
    parameter int PRE_W  = 5,
    parameter int CNT_W  = 8,
    parameter int DIV_W  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_addr,
    input  logic             bus_wr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic             event_in,
    input  logic             capture_in,
    output logic             tick_irq
);
    logic             run;
    logic             use_event;
    logic             tick;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] latched;
    logic             wr_count;
    logic             wr_ctrl;

    assign wr_count = bus_wr && (bus_addr == ADDR_COUNT);
    assign wr_ctrl  = bus_wr && (bus_addr == ADDR_CTRL);

    tmr_tick_src #(.DIV_W(DIV_W), .STAGES(STAGES)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .use_event (use_event),
        .event_in  (event_in),
        .tick      (tick)
    );

    tmr_count_core #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .wr_count  (wr_count),
        .wr_ctrl   (wr_ctrl),
        .wdata     (bus_wdata),
        .run       (run),
        .use_event (use_event),
        .count     (count),
        .irq       (tick_irq)
    );

    tmr_capture #(.CNT_W(CNT_W), .STAGES(STAGES)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_in (capture_in),
        .count      (count),
        .latched    (latched)
    );

    // Read mux: the control address returns the capture latch
    always_comb begin
        bus_rdata = (bus_addr == ADDR_CTRL) ? latched : count;
    end
endmodule

// File: tb/prescaled_capture_timer_tb.sv
module prescaled_capture_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_addr = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       event_in = 1'b0;
    logic       capture_in = 1'b0;
    logic       tick_irq;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int irq_seen = 0;
    int wide_pulses = 0;
    logic irq_prev = 1'b0;

    always #4 clk = ~clk;

    prescaled_capture_timer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .event_in   (event_in),
        .capture_in (capture_in),
        .tick_irq   (tick_irq)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Pulse monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (tick_irq) irq_seen <= irq_seen + 1;
        if (tick_irq && irq_prev) wide_pulses <= wide_pulses + 1;
        irq_prev <= tick_irq;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        bad = bad + 1;
        total = total + 1;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic check(input string req, input int act, input int exp);
        total = total + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output int v);
        @(negedge clk);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic evt_pulse();
        @(negedge clk); event_in = 1'b1;
        repeat (3) @(negedge clk);
        event_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic cap_pulse();
        @(negedge clk); capture_in = 1'b1;
        repeat (3) @(negedge clk);
        capture_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_irq(output int t);
        do @(negedge clk); while (!tick_irq);
        t = cyc;
    endtask

    initial begin
        int v;
        int base;
        int t0;
        int t1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(1'b0, v); check("R1 count after reset", v, 0);
        rd(1'b1, v); check("R1 capture after reset", v, 0);
        check("R1 irq after reset", int'(tick_irq), 0);

        // R2: data write loads the live counter
        wr(1'b0, 8'hA7);
        rd(1'b0, v); check("R2 count after data write", v, 8'hA7);

        // R7: stopped in event mode, events have no effect
        wr(1'b1, 8'h40);
        for (int i = 0; i < 6; i++) evt_pulse();
        repeat (6) @(negedge clk);
        rd(1'b0, v); check("R7 count while stopped", v, 8'hA7);

        // R3 R4 R6: event-mode sweep of prescale and reload
        for (int p = 0; p < 4; p++) begin
            for (int r = 0; r < 4; r++) begin
                int n;
                int s;
                wr(1'b1, 8'h00);
                wr(1'b0, 8'(r));
                base = irq_seen;
                wr(1'b1, 8'hC0 | 8'(p));
                n = 2 * (p + 1) * (r + 1) + 1;
                for (int k = 0; k < n; k++) evt_pulse();
                repeat (6) @(negedge clk);
                s = n / (p + 1);
                rd(1'b0, v);
                check($sformatf("R3 count p=%0d r=%0d", p, r), v, r - (s % (r + 1)));
                check($sformatf("R4 irq count p=%0d r=%0d", p, r), irq_seen - base, s / (r + 1));
            end
        end

        // R8: rewrite of control while running keeps the prescaler phase
        wr(1'b1, 8'h00);
        wr(1'b0, 8'd5);
        wr(1'b1, 8'hC3);
        evt_pulse(); evt_pulse();
        wr(1'b1, 8'hC3);
        evt_pulse(); evt_pulse();
        repeat (6) @(negedge clk);
        rd(1'b0, v); check("R8 count after running rewrite", v, 4);

        // R5: clock-divider mode period
        for (int j = 0; j < 3; j++) begin
            int p;
            int r;
            p = (j == 0) ? 0 : ((j == 1) ? 1 : 3);
            r = (j == 0) ? 0 : ((j == 1) ? 2 : 1);
            wr(1'b1, 8'h00);
            wr(1'b0, 8'(r));
            wr(1'b1, 8'h80 | 8'(p));
            wait_irq(t0);
            wait_irq(t1);
            check($sformatf("R5 period p=%0d r=%0d", p, r), t1 - t0, 16 * (p + 1) * (r + 1));
        end

        // R9: capture against a known event-driven count
        for (int j = 0; j < 2; j++) begin
            int k;
            k = (j == 0) ? 3 : 10;
            wr(1'b1, 8'h00);
            wr(1'b0, 8'd200);
            wr(1'b1, 8'hC0);
            for (int i = 0; i < k; i++) evt_pulse();
            repeat (6) @(negedge clk);
            cap_pulse();
            repeat (4) @(negedge clk);
            rd(1'b1, v); check($sformatf("R9 captured k=%0d", k), v, 200 - k);
            for (int i = 0; i < 5; i++) evt_pulse();
            repeat (6) @(negedge clk);
            rd(1'b1, v); check($sformatf("R9 latch holds k=%0d", k), v, 200 - k);
            rd(1'b0, v); check($sformatf("R9 live count k=%0d", k), v, 195 - k);
        end

        // R4: every request pulse lasted one cycle
        check("R4 wide irq pulses", wide_pulses, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule